// File: doc/BRIEF.md
# Dispatch Group Former and In-Flight Group Tracker

This block takes a stream of decoded instructions, each already split into two or three internal operations, and packs those operations into five-slot dispatch groups. Four body slots take ordinary operations in arrival order. The fifth slot takes only a branch operation. A group leaves the block as one unit with a single group tag, and its unused slots are filled with no-ops.

Every issued group gets an entry in a circular completion table. Execution units report each finished operation by tag and slot. The oldest group retires once all five of its slots are done, and groups retire strictly in order, one per cycle at most. The table size limits how many groups can be in flight. When the table is full and a finished group is waiting, the input stalls. A flush input drops everything in flight and restarts tag allocation.

Top module: `dgrp_top`

## Requirements
- R1: After reset, `inReady` is 1 and both `grpValid` and `retValid` are 0.
- R2: An instruction's non-branch ops go into body slots 0 to 3, starting at the first free slot and keeping their input order. Slot 4 holds an op (`grpLive[4]`=1) only when that op is a branch. Dead slots carry payload 0 and a `grpLive` bit of 0. `grpOps` slot k sits at bits [k*OP_W +: OP_W].
- R3: The ops of one instruction are never split across groups. If an instruction's non-branch ops do not fit in the free body slots, `inReady` stays 0 for that cycle and the pending group closes with padding. The instruction is accepted in a later cycle and starts a new group.
- R4: An instruction that ends in a branch (`inBr` bit `inCount-1` set; only an instruction's last op may be a branch) closes its group when it is accepted. The group is offered on `grpValid` in the next cycle, with the branch in slot 4.
- R5: If a partial group is pending and `inValid` is 0 for a cycle, the group closes with padding at the end of that cycle.
- R6: Group tags are handed out as 0, 1, 2 and so on, and wrap from DEPTH-1 back to 0. A group is issued in every cycle in which `grpValid` is 1.
- R7: When DEPTH groups are in flight and a closed group is waiting, `inReady` is 0 and `grpValid` is 0 until a group retires.
- R8: A done report (`doneValid`, `doneTag`, `doneSlot`) marks one slot finished. No-op slots count as finished from issue, so a group can retire once its live slots are reported.
- R9: Retirement goes strictly in tag order, one group per cycle at most. A younger group that is fully done waits for every older group to retire.
- R10: A flush drops all in-flight groups, the waiting group and the partial group. After a flush nothing retires, and the next issued group has tag 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drops all groups and restarts tags at 0 |
| inValid | input | 1 | An instruction is presented |
| inReady | output | 1 | The instruction is accepted this cycle |
| inCount | input | 2 | Number of ops in the instruction (2 or 3) |
| inOps | input | 3*OP_W | Op payloads; op j at [j*OP_W +: OP_W] |
| inBr | input | 3 | Per-op branch mark; only the last op may be set |
| grpValid | output | 1 | A group is issued this cycle |
| grpTag | output | TAG_W | Tag of the issued group |
| grpOps | output | 5*OP_W | Slot payloads of the issued group |
| grpLive | output | 5 | Per-slot mark: 1 for a real op, 0 for a no-op |
| doneValid | input | 1 | An op has finished |
| doneTag | input | TAG_W | Tag of the finished op's group |
| doneSlot | input | 3 | Slot index of the finished op |
| retValid | output | 1 | The oldest group retires this cycle |
| retTag | output | TAG_W | Tag of the retiring group |

## Verification
The bench keeps the default table depth of 20 groups (5-bit tags) and the default 16-bit payload. With these defaults, twenty-odd groups are enough to fill the table, stall the input with a group waiting, wrap the tag counter through 19 back to 0, and then flush with the table full. The directed scenarios also retire groups out of their completion order, which shows in-order retirement and the no-op slots that start out done.

// File: rtl/dgrp_pkg.sv
package dgrp_pkg;

  localparam int SLOTS     = 5;
  localparam int BODY      = 4;
  localparam int MAX_OPS   = 3;
  localparam int SLOT_IDX_W = 3;

  // control -> datapath strobes, one set per cycle
  typedef struct packed {
    logic       flush;
    logic       take;      // instruction accepted
    logic       appendBr;  // accepted instruction ends in a branch
    logic       closeNow;  // group moves to the issue register
    logic       issue;     // held group enters the table
    logic [2:0] base;      // first free body slot
    logic [2:0] nbCnt;     // non-branch ops in the instruction
  } dgStrobe_t;

endpackage

// File: rtl/dgrp_ctrl.sv
module dgrp_ctrl
  import dgrp_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             inValid,
  input  logic [1:0]       inCount,
  input  logic [2:0]       inBr,
  output logic             inReady,
  input  logic             headDone,
  output dgStrobe_t        strb,
  output logic [TAG_W-1:0] tailIdx,
  output logic [TAG_W-1:0] headIdx,
  output logic             grpValid,
  output logic             retValid
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(DEPTH);

  logic [2:0]       partCnt;
  logic             holdValid;
  logic [CNT_W-1:0] count;

  logic       hasBr, fits, holdFree, issue, retire;
  logic       take, forceClose, idleClose, closeNow;
  logic [2:0] opCnt, nbCnt;

  always_comb begin
    case (inCount)
      2'd3:    hasBr = inBr[2];
      2'd2:    hasBr = inBr[1];
      default: hasBr = inBr[0];
    endcase
    opCnt = (inCount == 2'd3) ? 3'd3 : 3'd2;
    nbCnt = opCnt - {2'b00, hasBr};
  end

  assign fits       = ({1'b0, partCnt} + {1'b0, nbCnt}) <= 4'(BODY);
  assign issue      = holdValid && (count < FULL) && !flush;
  assign holdFree   = !holdValid || issue;
  assign inReady    = !flush && holdFree && fits;
  assign take       = inValid && inReady;
  assign forceClose = inValid && !fits && holdFree && !flush && (partCnt != 3'd0);
  assign idleClose  = !inValid && (partCnt != 3'd0) && holdFree && !flush;
  assign closeNow   = (take && hasBr) || forceClose || idleClose;
  assign retire     = (count != '0) && headDone && !flush;

  assign grpValid = issue;
  assign retValid = retire;

  always_comb begin
    strb          = '0;
    strb.flush    = flush;
    strb.take     = take;
    strb.appendBr = take && hasBr;
    strb.closeNow = closeNow;
    strb.issue    = issue;
    strb.base     = partCnt;
    strb.nbCnt    = nbCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partCnt   <= '0;
      holdValid <= 1'b0;
      count     <= '0;
      tailIdx   <= '0;
      headIdx   <= '0;
    end else if (flush) begin
      partCnt   <= '0;
      holdValid <= 1'b0;
      count     <= '0;
      tailIdx   <= '0;
      headIdx   <= '0;
    end else begin
      if (closeNow)  partCnt <= '0;
      else if (take) partCnt <= partCnt + nbCnt;

      if (closeNow)   holdValid <= 1'b1;
      else if (issue) holdValid <= 1'b0;

      if (issue) tailIdx <= (tailIdx == LAST_TAG) ? '0 : tailIdx + 1'b1;
      if (retire) headIdx <= (headIdx == LAST_TAG) ? '0 : headIdx + 1'b1;

      case ({issue, retire})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R7: a full table with a waiting group blocks the input
  p_full_stall_r7: assert property (@(posedge clk) disable iff (!rstN)
    (holdValid && count == FULL && !flush) |-> !inReady);

  // R3: an instruction that does not fit forces the pending group out
  p_split_close_r3: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !fits && holdFree && !flush) |=> (partCnt == 3'd0 && holdValid));

  // R5: an idle cycle closes a pending partial group
  p_idle_close_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && partCnt != 3'd0 && !holdValid && !flush) |=> (holdValid && partCnt == 3'd0));

  // R6: tag allocation wraps after the last entry
  p_tag_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issue && tailIdx == LAST_TAG) |=> tailIdx == '0);

  // R9: retirement needs an occupied table
  p_retire_occupied_r9: assert property (@(posedge clk) disable iff (!rstN)
    retValid |-> count != '0);

  // R10: flush empties everything
  p_flush_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> (count == '0 && !holdValid && partCnt == 3'd0 && tailIdx == '0));

endmodule

// File: rtl/dgrp_data.sv
module dgrp_data
  import dgrp_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int OP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dgStrobe_t               strb,
  input  logic [TAG_W-1:0]        tailIdx,
  input  logic [TAG_W-1:0]        headIdx,
  input  logic [MAX_OPS*OP_W-1:0] inOps,
  input  logic                    doneValid,
  input  logic [TAG_W-1:0]        doneTag,
  input  logic [SLOT_IDX_W-1:0]   doneSlot,
  output logic                    headDone,
  output logic [SLOTS*OP_W-1:0]   grpOps,
  output logic [SLOTS-1:0]        grpLive
);

  localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(DEPTH - 1);

  logic [OP_W-1:0]  partOps [BODY];
  logic [BODY-1:0]  partLive;
  logic [OP_W-1:0]  mOps    [BODY];
  logic [BODY-1:0]  mLive;
  logic [OP_W-1:0]  brOp;
  logic [OP_W-1:0]  holdOps [SLOTS];
  logic [SLOTS-1:0] holdLive;
  logic [SLOTS-1:0] doneMask [DEPTH];

  // merge the incoming non-branch ops into the free body slots
  always_comb begin
    logic [3:0] idx;
    for (int k = 0; k < BODY; k++) begin
      mOps[k]  = partOps[k];
      mLive[k] = partLive[k];
    end
    for (int j = 0; j < MAX_OPS; j++) begin
      idx = 4'(strb.base) + 4'(j);
      if (strb.take && (3'(j) < strb.nbCnt) && (idx < 4'(BODY))) begin
        mOps[idx[1:0]]  = inOps[j*OP_W +: OP_W];
        mLive[idx[1:0]] = 1'b1;
      end
    end
    case (strb.nbCnt)
      3'd0:    brOp = inOps[0 +: OP_W];
      3'd1:    brOp = inOps[OP_W +: OP_W];
      default: brOp = inOps[2*OP_W +: OP_W];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      partLive <= '0;
      holdLive <= '0;
      for (int k = 0; k < BODY; k++) partOps[k] <= '0;
      for (int k = 0; k < SLOTS; k++) holdOps[k] <= '0;
    end else if (strb.flush) begin
      partLive <= '0;
      holdLive <= '0;
      for (int k = 0; k < BODY; k++) partOps[k] <= '0;
    end else begin
      if (strb.closeNow) begin
        for (int k = 0; k < BODY; k++) begin
          holdOps[k]  <= mOps[k];
          holdLive[k] <= mLive[k];
          partOps[k]  <= '0;
        end
        holdOps[SLOTS-1]  <= strb.appendBr ? brOp : '0;
        holdLive[SLOTS-1] <= strb.appendBr;
        partLive          <= '0;
      end else if (strb.take) begin
        for (int k = 0; k < BODY; k++) partOps[k] <= mOps[k];
        partLive <= mLive;
      end
    end
  end

  // completion table: one done bit per slot per entry
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int e = 0; e < DEPTH; e++) doneMask[e] <= '0;
    end else if (strb.flush) begin
      for (int e = 0; e < DEPTH; e++) doneMask[e] <= '0;
    end else begin
      if (doneValid && doneTag <= LAST_TAG && doneSlot < SLOT_IDX_W'(SLOTS))
        doneMask[doneTag][doneSlot] <= 1'b1;
      if (strb.issue)
        doneMask[tailIdx] <= ~holdLive;
    end
  end

  assign headDone = &doneMask[headIdx];

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_out
      assign grpOps[g*OP_W +: OP_W] = holdOps[g];
    end
  endgenerate
  assign grpLive = holdLive;

  // R2: a close without a branch leaves slot 4 empty
  p_slot4_branch_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.closeNow && !strb.appendBr && !strb.flush) |=> !holdLive[SLOTS-1]);

  // R8: padding slots are marked done when the entry is written
  p_noop_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.issue && !(doneValid && doneTag == tailIdx)) |=>
      (&(doneMask[$past(tailIdx)] | $past(holdLive))));

endmodule

// File: rtl/dgrp_top.sv
module dgrp_top
  import dgrp_pkg::*;
#(
  parameter int DEPTH = 20,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int OP_W  = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    flush,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [1:0]              inCount,
  input  logic [3*OP_W-1:0]       inOps,
  input  logic [2:0]              inBr,
  output logic                    grpValid,
  output logic [TAG_W-1:0]        grpTag,
  output logic [5*OP_W-1:0]       grpOps,
  output logic [4:0]              grpLive,
  input  logic                    doneValid,
  input  logic [TAG_W-1:0]        doneTag,
  input  logic [2:0]              doneSlot,
  output logic                    retValid,
  output logic [TAG_W-1:0]        retTag
);

  dgStrobe_t        strb;
  logic [TAG_W-1:0] tailIdx, headIdx;
  logic             headDone;

  dgrp_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .flush(flush),
    .inValid(inValid), .inCount(inCount), .inBr(inBr), .inReady(inReady),
    .headDone(headDone), .strb(strb), .tailIdx(tailIdx), .headIdx(headIdx),
    .grpValid(grpValid), .retValid(retValid)
  );

  dgrp_data #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .tailIdx(tailIdx), .headIdx(headIdx),
    .inOps(inOps), .doneValid(doneValid), .doneTag(doneTag), .doneSlot(doneSlot),
    .headDone(headDone), .grpOps(grpOps), .grpLive(grpLive)
  );

  assign grpTag = tailIdx;
  assign retTag = headIdx;

endmodule

// File: tb/test_dgrp_top.sv
module test_dgrp_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 20;
  localparam int TAG_W = 5;
  localparam int OP_W  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flush = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [1:0] inCount = 2'd2;
  logic [3*OP_W-1:0] inOps = '0;
  logic [2:0] inBr = '0;
  logic grpValid;
  logic [TAG_W-1:0] grpTag;
  logic [5*OP_W-1:0] grpOps;
  logic [4:0] grpLive;
  logic doneValid = 1'b0;
  logic [TAG_W-1:0] doneTag = '0;
  logic [2:0] doneSlot = '0;
  logic retValid;
  logic [TAG_W-1:0] retTag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  int gN = 0;
  int gTag [64];
  logic [5*OP_W-1:0] gOps [64];
  logic [4:0] gLive [64];
  int rN = 0;
  int rTag [64];

  always #(CLK_PERIOD/2) clk = ~clk;

  dgrp_top #(.DEPTH(DEPTH), .TAG_W(TAG_W), .OP_W(OP_W)) i_dgrp_top (
    .clk(clk), .rstN(rstN), .flush(flush), .inValid(inValid), .inReady(inReady),
    .inCount(inCount), .inOps(inOps), .inBr(inBr), .grpValid(grpValid),
    .grpTag(grpTag), .grpOps(grpOps), .grpLive(grpLive), .doneValid(doneValid),
    .doneTag(doneTag), .doneSlot(doneSlot), .retValid(retValid), .retTag(retTag)
  );

  // record issued and retired groups, sampled between edges
  always begin
    @(negedge clk);
    #2;
    if (rstN && grpValid && gN < 64) begin
      gTag[gN] = int'(grpTag);
      gOps[gN] = grpOps;
      gLive[gN] = grpLive;
      gN++;
    end
    if (rstN && retValid && rN < 64) begin
      rTag[rN] = int'(retTag);
      rN++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chkGroup(input string req, input int idx, input int tag,
                          input int o0, input int o1, input int o2, input int o3,
                          input int o4, input int live);
    chk({req, " tag"}, gTag[idx], tag);
    chk({req, " slot0"}, int'(gOps[idx][0*OP_W +: OP_W]), o0);
    chk({req, " slot1"}, int'(gOps[idx][1*OP_W +: OP_W]), o1);
    chk({req, " slot2"}, int'(gOps[idx][2*OP_W +: OP_W]), o2);
    chk({req, " slot3"}, int'(gOps[idx][3*OP_W +: OP_W]), o3);
    chk({req, " slot4"}, int'(gOps[idx][4*OP_W +: OP_W]), o4);
    chk({req, " live"}, int'(gLive[idx]), live);
  endtask

  task automatic sendInstr(input int cnt, input int a, input int b, input int c,
                           input logic [2:0] br, output int stalls);
    stalls = 0;
    @(negedge clk);
    inValid = 1'b1;
    inCount = 2'(cnt);
    inOps = {OP_W'(c), OP_W'(b), OP_W'(a)};
    inBr = br;
    #1;
    while (!inReady) begin
      stalls++;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic reportDone(input int tag, input int slot);
    @(negedge clk);
    doneValid = 1'b1;
    doneTag = TAG_W'(tag);
    doneSlot = 3'(slot);
    @(posedge clk);
    #1;
    doneValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #3;
  endtask

  task automatic testReset();
    @(negedge clk);
    #1;
    chk("R1 inReady", int'(inReady), 1);
    chk("R1 grpValid", int'(grpValid), 0);
    chk("R1 retValid", int'(retValid), 0);
  endtask

  task automatic testPackIdle();
    int s, g0;
    g0 = gN;
    sendInstr(2, 'h11, 'h12, 0, 3'b000, s);
    sendInstr(2, 'h13, 'h14, 0, 3'b000, s);
    idle(4);
    chk("R5 one group after idle", gN - g0, 1);
    chkGroup("R2 R6 packed", g0, 0, 'h11, 'h12, 'h13, 'h14, 0, 'b01111);
  endtask

  task automatic testBranch();
    int s, g0;
    g0 = gN;
    sendInstr(3, 'h21, 'h22, 'h23, 3'b100, s);
    @(negedge clk);
    #1;
    chk("R4 issued next cycle", int'(grpValid), 1);
    idle(2);
    chk("R4 one group", gN - g0, 1);
    chkGroup("R4 branch slot", g0, 1, 'h21, 'h22, 0, 0, 'h23, 'b10011);
  endtask

  task automatic testSplit();
    int s, g0;
    g0 = gN;
    sendInstr(3, 'h31, 'h32, 'h33, 3'b000, s);
    sendInstr(2, 'h34, 'h35, 0, 3'b000, s);
    chk("R3 stall on no fit", s, 1);
    idle(4);
    chk("R3 two groups", gN - g0, 2);
    chkGroup("R3 first", g0, 2, 'h31, 'h32, 'h33, 0, 0, 'b00111);
    chkGroup("R3 second", g0 + 1, 3, 'h34, 'h35, 0, 0, 0, 'b00011);
  endtask

  task automatic testRetire();
    int r0;
    r0 = rN;
    reportDone(3, 0);
    reportDone(3, 1);
    idle(2);
    chk("R9 young waits", rN - r0, 0);
    for (int k = 0; k < 4; k++) reportDone(0, k);
    reportDone(1, 0);
    reportDone(1, 1);
    idle(1);
    chk("R8 partial not retired", rN - r0, 1);
    reportDone(1, 4);
    for (int k = 0; k < 3; k++) reportDone(2, k);
    idle(3);
    chk("R9 retire count", rN - r0, 4);
    for (int k = 0; k < 4; k++) chk("R9 retire order", rTag[r0 + k], k);
    chk("R9 table idle", int'(retValid), 0);
  endtask

  task automatic testFullWrapFlush();
    int s, g0, r0;
    g0 = gN;
    for (int k = 0; k < 21; k++) sendInstr(2, 'h40 + k, 'h80 + k, 0, 3'b010, s);
    // 20 groups in flight, the 21st waits
    @(negedge clk);
    inValid = 1'b1;
    inCount = 2'd2;
    inOps = {OP_W'(0), OP_W'('hCC), OP_W'('hCB)};
    inBr = 3'b010;
    #1;
    chk("R7 ready low when full", int'(inReady), 0);
    chk("R7 no issue when full", int'(grpValid), 0);
    idle(3);
    chk("R7 still blocked", gN - g0, 20);
    for (int k = 0; k < 20; k++) chk("R6 tag sequence", gTag[g0 + k], (4 + k) % DEPTH);
    chkGroup("R2 branch only group", g0, 4, 'h40, 0, 0, 0, 'h80, 'b10001);
    r0 = rN;
    reportDone(4, 0);
    reportDone(4, 4);
    idle(4);
    chk("R8 retire head", rN - r0, 1);
    chk("R6 wrapped tag", gTag[g0 + 20], 4);
    chk("R7 resumed", gN - g0, 21);
    // flush with a full table and a waiting group
    @(negedge clk);
    inValid = 1'b0;
    flush = 1'b1;
    @(posedge clk);
    #1;
    flush = 1'b0;
    idle(3);
    chk("R10 no retire", int'(retValid), 0);
    chk("R10 nothing issued", gN - g0, 21);
    chk("R10 ready", int'(inReady), 1);
    sendInstr(2, 'h55, 'h56, 0, 3'b010, s);
    idle(2);
    chk("R10 restart count", gN - g0, 22);
    chkGroup("R10 restart tag", g0 + 21, 0, 'h55, 0, 0, 0, 'h56, 'b10001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testPackIdle();
    testBranch();
    testSplit();
    testRetire();
    testFullWrapFlush();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule